// File: doc/BRIEF.md
# Four-Channel Pulse-Width Generator with Boundary-Committed Settings

This block drives four independent pulse-width outputs. Each channel counts steps of a shared 1 MHz enable pulse, optionally slowed by 2, 4 or 8, through a programmable period. The output is active for the first part of every period. Software programs each channel through a small memory-mapped register set with three registers per channel: period length, active length, and a control word that holds the step divider and an output inversion bit.

Every write lands in a per-channel staging copy first. A period write arms the staged set. The running channel adopts all staged values together at the end of its current period, so the output never shows a mix of old and new settings. A period value of zero switches the channel off. The period already in progress still completes, and after that the output stays low. The usual programming order is control, then active length, then period. The period write is the commit trigger.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and every mapped register reads 0.
- R2: Per channel n (0..3): the period register is at byte offset 0x400+4n, the active-length register at 0x420+4n, and the control register at 0x440+4n. Period and active length keep the low 16 bits of the write data. Control keeps bits [1:0] (divider code) and bit 5 (invert). Unused bits read 0. Reads return the staged value last written.
- R3: A read of any other offset, including offsets not aligned to 4 bytes, returns 0. A write to such an offset changes no register and no output.
- R4: Control and active-length writes leave the output unchanged until the period register of that channel has been written and the running period has ended.
- R5: A shared tick counter modulo 8 advances on every enable pulse. A channel with divider code d (0..3) advances its count on an enable pulse only when the low d bits of that shared counter are all ones.
- R6: Before inversion, the output is active while the count is below the active length. An active length at or above the period gives a constant active level, and an active length of 0 gives a constant inactive level.
- R7: Control bit 5 inverts the output of an enabled channel.
- R8: The count runs from 0 to period−1 and then wraps. Staged values move into the running set only at this wrap.
- R9: An idle channel with an armed nonzero period loads the staged values on the next clock edge and starts at count 0.
- R10: Writing 0 to the period register lets the current period finish. After that the output stays low, regardless of the invert bit.
- R11: The four channels run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 MHz enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 4 | Channel outputs, bit n is channel n |

## Verification
A wrong running count or a wrong running setting appears on the affected output within one period. Either the active edge falls at the wrong place, or the wrap comes early or late. A staged value adopted too early changes the output within a single step of the write, long before the period end where it belongs. The bench therefore compares all four outputs against a behavioural model on every clock. A lost arm flag or a wrong idle state shows as a channel that never starts or never stops, and it is caught on the first cycle where the model expects the change.

// File: rtl/pwm_bank_pkg.sv
// Shared types and constants for the four-channel pulse-width block.
// Assumes a 16-bit count and a 2-bit divider code (steps divided by up to 8).
package pwm_bank_pkg;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned DIV_W  = 2;
    localparam int unsigned DIV_N  = 1 << DIV_W;
    localparam int unsigned PRE_W  = DIV_N - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             inv;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] period;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
// Derives one step enable per divider code from the shared 1 MHz tick.
// Assumes tick_i is a single-cycle pulse. Code k steps when the low k bits
// of the shared tick counter are all ones.
module pwm_prescaler
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [DIV_N-1:0] step_o
);
    logic [PRE_W-1:0] pre_q;

    // Free-running tick counter shared by all channels.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (tick_i) pre_q <= pre_q + 1'b1;
    end

    // One enable per divider code.
    for (genvar k = 0; k < DIV_N; k++) begin : g_step
        if (k == 0) begin : g_div1
            assign step_o[k] = tick_i;
        end else begin : g_divn
            assign step_o[k] = tick_i & (&pre_q[k-1:0]);
        end
    end

    // The shared counter only moves on a tick.
    AST_PRE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !tick_i) |=> $stable(pre_q)); // R5
endmodule

// File: rtl/pwm_bank_regs.sv
// Register file: address decode, staged settings, arm flags and read mux.
// Assumes single-cycle writes. An arm flag set by a period write wins over a
// commit acknowledge in the same cycle.
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned PER_BASE = 'h400,
    parameter int unsigned DUT_BASE = 'h420,
    parameter int unsigned CTL_BASE = 'h440,
    parameter int unsigned INV_BIT  = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NUM_CH-1:0] commit_i,
    output pwm_cfg_t          shadow_o [NUM_CH],
    output logic [NUM_CH-1:0] pend_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned STRIDE = 4;

    logic [NUM_CH-1:0] hit_per, hit_dut, hit_ctl;
    logic              any_hit;
    pwm_cfg_t          shadow_q [NUM_CH];
    logic [NUM_CH-1:0] pend_q;

    // Per-channel address match for each register kind.
    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            hit_per[ch] = (addr_i == ADDR_W'(PER_BASE + STRIDE*ch));
            hit_dut[ch] = (addr_i == ADDR_W'(DUT_BASE + STRIDE*ch));
            hit_ctl[ch] = (addr_i == ADDR_W'(CTL_BASE + STRIDE*ch));
        end
        any_hit = |{hit_per, hit_dut, hit_ctl};
    end

    // Staged settings and arm flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NUM_CH; ch++) shadow_q[ch] <= '0;
            pend_q <= '0;
        end else begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_en_i && hit_per[ch]) shadow_q[ch].period <= wdata_i[CNT_W-1:0];
                if (wr_en_i && hit_dut[ch]) shadow_q[ch].duty   <= wdata_i[CNT_W-1:0];
                if (wr_en_i && hit_ctl[ch]) begin
                    shadow_q[ch].div <= wdata_i[DIV_W-1:0];
                    shadow_q[ch].inv <= wdata_i[INV_BIT];
                end
                if (wr_en_i && hit_per[ch]) pend_q[ch] <= 1'b1;
                else if (commit_i[ch])      pend_q[ch] <= 1'b0;
            end
        end
    end

    // Read mux returns staged values; unmapped offsets read 0.
    always_comb begin
        rdata_o = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (hit_per[ch]) rdata_o[CNT_W-1:0] = shadow_q[ch].period;
            if (hit_dut[ch]) rdata_o[CNT_W-1:0] = shadow_q[ch].duty;
            if (hit_ctl[ch]) begin
                rdata_o[DIV_W-1:0] = shadow_q[ch].div;
                rdata_o[INV_BIT]   = shadow_q[ch].inv;
            end
        end
    end

    assign shadow_o = shadow_q;
    assign pend_o   = pend_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        AST_PERIOD_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && hit_per[ch]) |=> pend_q[ch]); // R4
        AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !any_hit) |=> $stable(shadow_q[ch])); // R3
    end
endmodule

// File: rtl/pwm_channel.sv
// One channel: running settings, period counter and output stage.
// Assumes step_i holds one enable per divider code and that the arm flag
// stays set until commit_o acknowledges it.
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_N-1:0] step_i,
    input  pwm_cfg_t         shadow_i,
    input  logic             pend_i,
    output logic             commit_o,
    output logic             pwm_o
);
    pwm_cfg_t         act_q;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step, at_end, load;

    // Step select, wrap detect and load decision.
    always_comb begin
        step   = step_i[act_q.div];
        at_end = ({1'b0, cnt_q} + 1'b1) == {1'b0, act_q.period};
        load   = run_q ? (step && at_end && pend_i) : pend_i;
    end

    // Running settings, enable and period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            act_q <= shadow_i;
            run_q <= (shadow_i.period != '0);
            cnt_q <= '0;
        end else if (run_q && step) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    assign commit_o = load;
    assign pwm_o    = run_q & ((cnt_q < act_q.duty) ^ act_q.inv);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < act_q.period)); // R8
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load) |=> $stable(act_q)); // R4
    AST_STOP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(run_q)) |-> $past(step && at_end)); // R10
    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !run_q && pend_i && shadow_i.period != '0) |=> (run_q && cnt_q == '0)); // R9
endmodule

// File: rtl/pwm_bank.sv
// Top of the four-channel pulse-width block: prescaler, register file and
// one channel instance per output.
// Assumes tick_i is a one-cycle enable pulse at 1 MHz, synchronous to clk.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NUM_CH-1:0] pwm_o
);
    logic [DIV_N-1:0]  step;
    pwm_cfg_t          shadow [NUM_CH];
    logic [NUM_CH-1:0] pend, commit;

    pwm_prescaler i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .step_o (step)
    );

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .commit_i (commit),
        .shadow_o (shadow),
        .pend_o   (pend),
        .rdata_o  (rdata_o)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_channel i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_i   (step),
            .shadow_i (shadow[ch]),
            .pend_i   (pend[ch]),
            .commit_o (commit[ch]),
            .pwm_o    (pwm_o[ch])
        );
    end
endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm;

    int total = 0, bad = 0, cyc = 0;
    string cur_req = "R1";
    bit   cmp_on = 1'b0;

    // Behavioural reference state
    int m_per[4], m_duty[4], m_div[4], m_inv[4], m_pend[4];
    int a_per[4], a_duty[4], a_div[4], a_inv[4], m_run[4], m_cnt[4];
    int m_pre;

    pwm_bank i_pwm_bank (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
    );

    always #5 clk = ~clk;

    // Reference model advanced on each rising edge.
    always @(posedge clk) begin
        bit cm[4];
        int st, msk, ld;
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_per[c]=0; m_duty[c]=0; m_div[c]=0; m_inv[c]=0; m_pend[c]=0;
                a_per[c]=0; a_duty[c]=0; a_div[c]=0; a_inv[c]=0; m_run[c]=0; m_cnt[c]=0;
            end
            m_pre = 0;
        end else begin
            for (int c = 0; c < 4; c++) begin
                msk = (1 << a_div[c]) - 1;
                st  = (tick && ((m_pre & msk) == msk)) ? 1 : 0;
                ld  = 0;
                if (m_run[c] != 0) begin
                    if (st != 0) begin
                        if (m_cnt[c] == a_per[c] - 1) begin
                            if (m_pend[c] != 0) ld = 1; else m_cnt[c] = 0;
                        end else m_cnt[c] = m_cnt[c] + 1;
                    end
                end else if (m_pend[c] != 0) ld = 1;
                if (ld != 0) begin
                    a_per[c]=m_per[c]; a_duty[c]=m_duty[c]; a_div[c]=m_div[c]; a_inv[c]=m_inv[c];
                    m_run[c] = (m_per[c] != 0) ? 1 : 0;
                    m_cnt[c] = 0;
                end
                cm[c] = (ld != 0);
            end
            for (int c = 0; c < 4; c++) begin
                if (wr_en && addr == 12'h400 + 4*c) begin
                    m_per[c] = wdata[15:0]; m_pend[c] = 1;
                end else if (cm[c]) m_pend[c] = 0;
                if (wr_en && addr == 12'h420 + 4*c) m_duty[c] = wdata[15:0];
                if (wr_en && addr == 12'h440 + 4*c) begin
                    m_div[c] = wdata[1:0]; m_inv[c] = wdata[5];
                end
            end
            if (tick) m_pre = (m_pre + 1) % 8;
        end
    end

    function automatic logic [3:0] model_out();
        logic [3:0] o;
        for (int c = 0; c < 4; c++)
            o[c] = (m_run[c] != 0) ? ((m_cnt[c] < a_duty[c]) ^ (a_inv[c] != 0)) : 1'b0;
        return o;
    endfunction

    function automatic int model_read(input int a);
        for (int c = 0; c < 4; c++) begin
            if (a == 'h400 + 4*c) return m_per[c];
            if (a == 'h420 + 4*c) return m_duty[c];
            if (a == 'h440 + 4*c) return m_div[c] | (m_inv[c] << 5);
        end
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Every-cycle output comparison, away from the rising edge.
    always @(negedge clk) begin
        cyc++;
        if (cmp_on && rst_n) check(cur_req, pwm, model_out());
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Tick generator: one pulse every third clock.
    initial begin
        int t = 0;
        forever begin
            @(negedge clk);
            t = (t + 1) % 3;
            tick = (t == 0);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 12'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
    endtask

    task automatic rd(input string req, input int a, input int exp);
        @(negedge clk);
        addr = 12'(a);
        #1;
        check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1: reset state
        #1 check("R1", pwm, 0);
        for (int c = 0; c < 4; c++) begin
            rd("R1", 'h400 + 4*c, 0);
            rd("R1", 'h420 + 4*c, 0);
            rd("R1", 'h440 + 4*c, 0);
        end
        // R2: field widths and readback
        cur_req = "R2";
        wr('h440, 32'hFFFF_FFFF);
        rd("R2", 'h440, 'h23);
        wr('h424, 32'h0001_2345);
        rd("R2", 'h424, 'h2345);
        rd("R2", 'h424, model_read('h424));
        // R3: unmapped offsets
        cur_req = "R3";
        wr('h460, 32'h5);
        wr('h402, 32'h7);
        wr('h000, 32'h9);
        rd("R3", 'h460, 0);
        rd("R3", 'h402, 0);
        rd("R3", 'h000, 0);
        rd("R3", 'h400, 0);
        #1 check("R3", pwm, 0);
        // Program all channels
        cur_req = "R5 R6 R7 R8 R9 R11";
        wr('h440, 0);     wr('h420, 3);  wr('h400, 5);
        wr('h444, 'h22);  wr('h424, 2);  wr('h404, 6);
        wr('h448, 1);     wr('h428, 9);  wr('h408, 4);
        wr('h44C, 3);     wr('h42C, 0);  wr('h40C, 3);
        idle(400);
        #1 check("R6", pwm[2], 1);
        check("R6", pwm[3], 0);
        // R4: staged value without period write has no effect
        cur_req = "R4";
        wr('h420, 1);
        wr('h440, 'h20);
        idle(200);
        rd("R4", 'h420, 1);
        cur_req = "R4 R8";
        wr('h400, 5);
        idle(200);
        // R10: disable an inverted channel
        cur_req = "R10";
        wr('h404, 0);
        idle(300);
        #1 check("R10", pwm[1], 0);
        // R9: restart idle channel
        cur_req = "R9";
        wr('h424, 1); wr('h444, 0); wr('h404, 3);
        idle(300);
        // Back-to-back updates
        cur_req = "R4 R11";
        wr('h408, 7); wr('h428, 2); wr('h408, 2);
        idle(300);
        cmp_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule